// File: doc/BRIEF.md
# Windowed Address Image Decoder

This block checks an incoming bus address against a small set of programmable address windows, called images, and reports which image claims the access. Each image has five settings: a base, a mask, a space bit that selects memory or I/O, a translation value and a translation enable. Only a fixed number of the most significant address bits take part in the compare. The remaining low bits decide nothing and always pass through. On a hit the block gives the index of the winning image, a one-hot hit vector and the address rewritten into the target space.

A requester pulses a strobe with the address and the access type. The result becomes valid after one, two or three wait states, chosen per request by a speed select. After that it holds until the next strobe. Every image setting leaves reset with a defined value, so the decoder works with no software setup. A single write port with an image number and a field code changes the settings.

Top module: `addr_img_decoder`

## Requirements
- R1: Only address bits [31:12] (DEC_BITS=20 upper bits of a 32-bit address) take part in the compare. The low 12 bits never change whether an image hits and are copied unchanged into `dec_addr`.
- R2: An upper bit takes part in the compare only where the image's mask bit is 1. A 0 mask bit lets that bit take any value, which makes the window larger.
- R3: An image hits only if the `req_io` of the request equals its space bit, where 0 means memory and 1 means I/O.
- R4: An image whose mask is all zeros never hits, whatever the address.
- R5: When an image hits with translation enabled, the upper bits of `dec_addr` become (addr AND NOT mask) OR (xlat AND mask). When translation is off, or when no image hits, `dec_addr` equals `req_addr`.
- R6: If several images match, the lowest index wins. `dec_img` is that index, `dec_hit_vec` has exactly that one bit set, and `dec_hit` is 1. On a miss, `dec_hit`, `dec_img` and `dec_hit_vec` are all 0.
- R7: `wait_sel` is sampled with `req`. The values 0, 1 and 2 (and also 3) give 1, 2 and 3 wait states. `dec_valid` drops on the clock edge that samples `req` and rises exactly that many edges later.
- R8: Reset values are as follows. Image 0 has base 0x00000 and mask 0xFFF00, memory, translation off. Image 1 has base 0x80000 and mask 0xF0000, memory, translation 0x10000 enabled. Image 2 has base 0x40000 and mask 0xFFFFF, I/O, translation off. Images 3 to 5 have all fields zero. All outputs reset to zero.
- R9: A write with `cfg_we`=1 updates one field of image `cfg_img`, chosen by `cfg_field`: 0 sets the base, 1 the mask, 2 the space bit (`cfg_data[0]`), 3 the translation value, 4 the translation enable (`cfg_data[0]`). An image number of 6 or higher, or a field code of 5 to 7, changes nothing.
- R10: Once valid, the outputs stay unchanged until the next `req`. A write sampled on the same edge as `req`, or during the wait states, affects only later requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Decode request strobe |
| req_addr | input | 32 | Address to decode |
| req_io | input | 1 | Access type: 0 memory, 1 I/O |
| wait_sel | input | 2 | Speed select: 0 fast, 1 medium, 2/3 slow |
| cfg_we | input | 1 | Setting write enable |
| cfg_img | input | 3 | Image number for the write |
| cfg_field | input | 3 | Field code for the write |
| cfg_data | input | 20 | Write data |
| dec_valid | output | 1 | Result is valid |
| dec_hit | output | 1 | An image was hit |
| dec_img | output | 3 | Index of the winning image |
| dec_hit_vec | output | 6 | One-hot vector of the winning image |
| dec_addr | output | 32 | Translated or passed-through address |

## Verification
A wrong base, mask or space setting inside the block appears at the ports as a wrong `dec_hit`, `dec_img` or `dec_hit_vec`. It shows on the first request that falls in the affected window, as soon as `dec_valid` rises. A wrong wait-state count appears as `dec_valid` rising one or more edges early or late. A wrong translation field or enable appears only in the upper bits of `dec_addr`, so requests are chosen both inside and outside each window. A setting corrupted by an ignored write stays hidden until a later request reaches that image, so the bench decodes again after each such write.

// File: rtl/addr_img_pkg.sv
package addr_img_pkg;

  typedef enum logic [2:0] {
    FLD_BASE  = 3'd0,
    FLD_MASK  = 3'd1,
    FLD_SPACE = 3'd2,
    FLD_XLAT  = 3'd3,
    FLD_XEN   = 3'd4
  } fld_e;

  typedef enum logic [1:0] {
    SPD_FAST   = 2'd0,
    SPD_MEDIUM = 2'd1,
    SPD_SLOW   = 2'd2,
    SPD_SLOW_X = 2'd3
  } spd_e;

  function automatic logic [1:0] wait_states(input logic [1:0] sel);
    case (spd_e'(sel))
      SPD_FAST:   wait_states = 2'd1;
      SPD_MEDIUM: wait_states = 2'd2;
      default:    wait_states = 2'd3;
    endcase
  endfunction

endpackage

// File: rtl/addr_img_regs.sv
module addr_img_regs
  import addr_img_pkg::*;
#(
  parameter int NUM_IMG  = 6,
  parameter int DEC_BITS = 20,
  parameter int IMG_W    = 3,
  parameter logic [NUM_IMG*DEC_BITS-1:0] RST_BASE = '0,
  parameter logic [NUM_IMG*DEC_BITS-1:0] RST_MASK = '0,
  parameter logic [NUM_IMG-1:0]          RST_SPACE = '0,
  parameter logic [NUM_IMG*DEC_BITS-1:0] RST_XLAT = '0,
  parameter logic [NUM_IMG-1:0]          RST_XEN  = '0
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              we,
  input  logic [IMG_W-1:0]                  img,
  input  logic [2:0]                        fld,
  input  logic [DEC_BITS-1:0]               data,
  output logic [NUM_IMG-1:0][DEC_BITS-1:0]  base_o,
  output logic [NUM_IMG-1:0][DEC_BITS-1:0]  mask_o,
  output logic [NUM_IMG-1:0]                space_o,
  output logic [NUM_IMG-1:0][DEC_BITS-1:0]  xlat_o,
  output logic [NUM_IMG-1:0]                xen_o
);

  for (genvar i = 0; i < NUM_IMG; i++) begin : g_img
    logic                sel;
    logic                base_en, mask_en, space_en, xlat_en, xen_en;
    logic [DEC_BITS-1:0] base_q, mask_q, xlat_q;
    logic                space_q, xen_q;

    assign sel = we && (img == IMG_W'(i));

    always_comb begin
      base_en  = 1'b0;
      mask_en  = 1'b0;
      space_en = 1'b0;
      xlat_en  = 1'b0;
      xen_en   = 1'b0;
      if (sel) begin
        case (fld)
          FLD_BASE:  base_en  = 1'b1;
          FLD_MASK:  mask_en  = 1'b1;
          FLD_SPACE: space_en = 1'b1;
          FLD_XLAT:  xlat_en  = 1'b1;
          FLD_XEN:   xen_en   = 1'b1;
          default:   ;
        endcase
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q  <= RST_BASE[i*DEC_BITS +: DEC_BITS];
        mask_q  <= RST_MASK[i*DEC_BITS +: DEC_BITS];
        space_q <= RST_SPACE[i];
        xlat_q  <= RST_XLAT[i*DEC_BITS +: DEC_BITS];
        xen_q   <= RST_XEN[i];
      end else begin
        if (base_en)  base_q  <= data;
        if (mask_en)  mask_q  <= data;
        if (space_en) space_q <= data[0];
        if (xlat_en)  xlat_q  <= data;
        if (xen_en)   xen_q   <= data[0];
      end
    end

    assign base_o[i]  = base_q;
    assign mask_o[i]  = mask_q;
    assign space_o[i] = space_q;
    assign xlat_o[i]  = xlat_q;
    assign xen_o[i]   = xen_q;
  end

  // A write aimed at an image number outside the set must leave every setting untouched.
  assert_bad_img_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (we && (int'(img) >= NUM_IMG)) |=>
      ($stable(base_o) && $stable(mask_o) && $stable(space_o) && $stable(xlat_o) && $stable(xen_o)));

  // A field code outside the defined set must also leave every setting untouched.
  assert_bad_fld_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (we && (fld > 3'd4)) |=>
      ($stable(base_o) && $stable(mask_o) && $stable(space_o) && $stable(xlat_o) && $stable(xen_o)));

endmodule

// File: rtl/addr_img_match.sv
module addr_img_match #(
  parameter int NUM_IMG  = 6,
  parameter int DEC_BITS = 20
) (
  input  logic [DEC_BITS-1:0]               addr_hi,
  input  logic                              io,
  input  logic [NUM_IMG-1:0][DEC_BITS-1:0]  base_i,
  input  logic [NUM_IMG-1:0][DEC_BITS-1:0]  mask_i,
  input  logic [NUM_IMG-1:0]                space_i,
  input  logic [NUM_IMG-1:0][DEC_BITS-1:0]  xlat_i,
  input  logic [NUM_IMG-1:0]                xen_i,
  output logic [NUM_IMG-1:0]                match_o,
  output logic [NUM_IMG-1:0][DEC_BITS-1:0]  xhi_o
);

  for (genvar i = 0; i < NUM_IMG; i++) begin : g_cmp
    logic implemented, field_eq, space_eq;

    assign implemented = |mask_i[i];
    assign field_eq    = ((addr_hi ^ base_i[i]) & mask_i[i]) == '0;
    assign space_eq    = (space_i[i] == io);
    assign match_o[i]  = implemented && field_eq && space_eq;

    assign xhi_o[i] = xen_i[i] ? ((addr_hi & ~mask_i[i]) | (xlat_i[i] & mask_i[i]))
                               : addr_hi;
  end

endmodule

// File: rtl/addr_img_prio.sv
module addr_img_prio #(
  parameter int NUM_IMG = 6,
  parameter int IMG_W   = 3
) (
  input  logic [NUM_IMG-1:0] match_i,
  output logic               hit_o,
  output logic [IMG_W-1:0]   idx_o,
  output logic [NUM_IMG-1:0] onehot_o
);

  always_comb begin
    hit_o    = 1'b0;
    idx_o    = '0;
    onehot_o = '0;
    for (int i = NUM_IMG - 1; i >= 0; i--) begin
      if (match_i[i]) begin
        hit_o    = 1'b1;
        idx_o    = IMG_W'(i);
        onehot_o = NUM_IMG'(1) << i;
      end
    end
  end

endmodule

// File: rtl/addr_img_pipe.sv
module addr_img_pipe
  import addr_img_pkg::*;
#(
  parameter int NUM_IMG = 6,
  parameter int IMG_W   = 3,
  parameter int ADDR_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req,
  input  logic [1:0]         wait_sel,
  input  logic               hit_i,
  input  logic [IMG_W-1:0]   idx_i,
  input  logic [NUM_IMG-1:0] vec_i,
  input  logic [ADDR_W-1:0]  addr_i,
  output logic               valid_o,
  output logic               hit_o,
  output logic [IMG_W-1:0]   idx_o,
  output logic [NUM_IMG-1:0] vec_o,
  output logic [ADDR_W-1:0]  addr_o
);

  logic [1:0] cnt_q, cnt_d;
  logic       valid_q, valid_d;

  always_comb begin
    cnt_d   = cnt_q;
    valid_d = valid_q;
    if (req) begin
      cnt_d   = wait_states(wait_sel);
      valid_d = 1'b0;
    end else if (cnt_q != 2'd0) begin
      cnt_d   = cnt_q - 2'd1;
      valid_d = (cnt_q == 2'd1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      valid_q <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_o  <= 1'b0;
      idx_o  <= '0;
      vec_o  <= '0;
      addr_o <= '0;
    end else if (req) begin
      hit_o  <= hit_i;
      idx_o  <= idx_i;
      vec_o  <= vec_i;
      addr_o <= addr_i;
    end
  end

  assign valid_o = valid_q;

  assert_onehot_vec_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(vec_o));

  assert_hit_agrees_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o == (vec_o != '0));

  assert_req_drops_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> !valid_o);

  assert_fast_one_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req && wait_sel == 2'd0) ##1 !req |=> valid_o);

  assert_hold_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !req) |=> (valid_o && $stable(addr_o) && $stable(idx_o) && $stable(vec_o)));

endmodule

// File: rtl/addr_img_decoder.sv
module addr_img_decoder
  import addr_img_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int NUM_IMG  = 6,
  parameter int DEC_BITS = 20,
  parameter logic [NUM_IMG*DEC_BITS-1:0] RST_BASE =
    {20'h00000, 20'h00000, 20'h00000, 20'h40000, 20'h80000, 20'h00000},
  parameter logic [NUM_IMG*DEC_BITS-1:0] RST_MASK =
    {20'h00000, 20'h00000, 20'h00000, 20'hFFFFF, 20'hF0000, 20'hFFF00},
  parameter logic [NUM_IMG-1:0] RST_SPACE = 6'b000100,
  parameter logic [NUM_IMG*DEC_BITS-1:0] RST_XLAT =
    {20'h00000, 20'h00000, 20'h00000, 20'h00000, 20'h10000, 20'h00000},
  parameter logic [NUM_IMG-1:0] RST_XEN = 6'b000010,
  localparam int IMG_W = (NUM_IMG > 1) ? $clog2(NUM_IMG) : 1,
  localparam int LOW_W = ADDR_W - DEC_BITS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic                req_io,
  input  logic [1:0]          wait_sel,
  input  logic                cfg_we,
  input  logic [IMG_W-1:0]    cfg_img,
  input  logic [2:0]          cfg_field,
  input  logic [DEC_BITS-1:0] cfg_data,
  output logic                dec_valid,
  output logic                dec_hit,
  output logic [IMG_W-1:0]    dec_img,
  output logic [NUM_IMG-1:0]  dec_hit_vec,
  output logic [ADDR_W-1:0]   dec_addr
);

  logic rst_meta_q, rst_sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic [NUM_IMG-1:0][DEC_BITS-1:0] base_w, mask_w, xlat_w, xhi_w;
  logic [NUM_IMG-1:0]               space_w, xen_w, match_w, onehot_w;
  logic                             hit_w;
  logic [IMG_W-1:0]                 idx_w;
  logic [DEC_BITS-1:0]              addr_hi;
  logic [ADDR_W-1:0]                out_addr_w;

  assign addr_hi = req_addr[ADDR_W-1 -: DEC_BITS];

  addr_img_regs #(
    .NUM_IMG(NUM_IMG), .DEC_BITS(DEC_BITS), .IMG_W(IMG_W),
    .RST_BASE(RST_BASE), .RST_MASK(RST_MASK), .RST_SPACE(RST_SPACE),
    .RST_XLAT(RST_XLAT), .RST_XEN(RST_XEN)
  ) u_regs (
    .clk(clk), .rst_n(rst_sync_q), .we(cfg_we), .img(cfg_img), .fld(cfg_field),
    .data(cfg_data), .base_o(base_w), .mask_o(mask_w), .space_o(space_w),
    .xlat_o(xlat_w), .xen_o(xen_w)
  );

  addr_img_match #(.NUM_IMG(NUM_IMG), .DEC_BITS(DEC_BITS)) u_match (
    .addr_hi(addr_hi), .io(req_io), .base_i(base_w), .mask_i(mask_w),
    .space_i(space_w), .xlat_i(xlat_w), .xen_i(xen_w),
    .match_o(match_w), .xhi_o(xhi_w)
  );

  addr_img_prio #(.NUM_IMG(NUM_IMG), .IMG_W(IMG_W)) u_prio (
    .match_i(match_w), .hit_o(hit_w), .idx_o(idx_w), .onehot_o(onehot_w)
  );

  generate
    if (LOW_W > 0) begin : g_low
      assign out_addr_w = hit_w ? {xhi_w[idx_w], req_addr[LOW_W-1:0]} : req_addr;
    end else begin : g_nolow
      assign out_addr_w = hit_w ? xhi_w[idx_w] : req_addr;
    end
  endgenerate

  addr_img_pipe #(.NUM_IMG(NUM_IMG), .IMG_W(IMG_W), .ADDR_W(ADDR_W)) u_pipe (
    .clk(clk), .rst_n(rst_sync_q), .req(req), .wait_sel(wait_sel),
    .hit_i(hit_w), .idx_i(idx_w), .vec_i(onehot_w), .addr_i(out_addr_w),
    .valid_o(dec_valid), .hit_o(dec_hit), .idx_o(dec_img), .vec_o(dec_hit_vec),
    .addr_o(dec_addr)
  );

  // The low address bits are never rewritten.
  assert_low_bits_pass_R1: assert property (@(posedge clk) disable iff (!rst_sync_q)
    req |=> dec_addr[LOW_W-1:0] == $past(req_addr[LOW_W-1:0]));

  // A miss leaves the address untouched.
  assert_miss_passthrough_R5: assert property (@(posedge clk) disable iff (!rst_sync_q)
    req |=> (dec_hit || dec_addr == $past(req_addr)));

endmodule

// File: tb/addr_img_decoder_test.sv
module addr_img_decoder_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req, req_io, cfg_we;
  logic [31:0] req_addr;
  logic [1:0]  wait_sel;
  logic [2:0]  cfg_img, cfg_field;
  logic [19:0] cfg_data;
  logic        dec_valid, dec_hit;
  logic [2:0]  dec_img;
  logic [5:0]  dec_hit_vec;
  logic [31:0] dec_addr;

  always #4 clk = ~clk;

  addr_img_decoder uut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_addr(req_addr), .req_io(req_io),
    .wait_sel(wait_sel), .cfg_we(cfg_we), .cfg_img(cfg_img), .cfg_field(cfg_field),
    .cfg_data(cfg_data), .dec_valid(dec_valid), .dec_hit(dec_hit), .dec_img(dec_img),
    .dec_hit_vec(dec_hit_vec), .dec_addr(dec_addr)
  );

  typedef struct {
    logic        hit;
    logic [2:0]  img;
    logic [5:0]  vec;
    logic [31:0] addr;
    int          lat;
    string       tag;
  } exp_t;

  exp_t q[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [19:0] m_base[6], m_mask[6], m_xl[6];
  logic        m_sp[6], m_xe[6];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic exp_t predict(input logic [31:0] a, input logic io, input logic [1:0] ws,
                                   input string tag);
    exp_t e;
    logic [19:0] hi;
    hi = a[31:12];
    e.hit = 0; e.img = 0; e.vec = 0; e.addr = a; e.tag = tag;
    e.lat = (ws == 0) ? 1 : (ws == 1) ? 2 : 3;
    for (int i = 0; i < 6; i++) begin
      if (!e.hit && m_mask[i] != 0 && m_sp[i] == io && ((hi ^ m_base[i]) & m_mask[i]) == 0) begin
        e.hit = 1;
        e.img = 3'(i);
        e.vec = 6'(1) << i;
        if (m_xe[i]) e.addr = {(hi & ~m_mask[i]) | (m_xl[i] & m_mask[i]), a[11:0]};
      end
    end
    return e;
  endfunction

  task automatic model_write(input logic [2:0] img, input logic [2:0] fld, input logic [19:0] d);
    if (img < 6) begin
      case (fld)
        3'd0: m_base[img] = d;
        3'd1: m_mask[img] = d;
        3'd2: m_sp[img]   = d[0];
        3'd3: m_xl[img]   = d;
        3'd4: m_xe[img]   = d[0];
        default: ;
      endcase
    end
  endtask

  task automatic wcfg(input logic [2:0] img, input logic [2:0] fld, input logic [19:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_img = img; cfg_field = fld; cfg_data = d;
    @(negedge clk);
    cfg_we = 0;
    model_write(img, fld, d);
  endtask

  task automatic issue(input logic [31:0] a, input logic io, input logic [1:0] ws, input string tag);
    exp_t e;
    e = predict(a, io, ws, tag);
    @(negedge clk);
    req = 1; req_addr = a; req_io = io; wait_sel = ws;
    @(negedge clk);
    req = 0;
    q.push_back(e);
    repeat (e.lat + 1) @(negedge clk);
  endtask

  // Scoreboard monitor: follows each request through its wait states.
  initial begin
    forever begin
      exp_t e;
      wait (q.size() != 0);
      e = q.pop_front();
      chk(dec_valid == 0, {e.tag, " R7 valid low after strobe"}, 32'(dec_valid), 0);
      for (int k = 1; k < e.lat; k++) begin
        @(negedge clk);
        chk(dec_valid == 0, {e.tag, " R7 valid low in wait"}, 32'(dec_valid), 0);
      end
      @(negedge clk);
      chk(dec_valid == 1, {e.tag, " R7 valid on time"}, 32'(dec_valid), 1);
      chk(dec_hit == e.hit, {e.tag, " hit"}, 32'(dec_hit), 32'(e.hit));
      chk(dec_img == e.img, {e.tag, " R6 index"}, 32'(dec_img), 32'(e.img));
      chk(dec_hit_vec == e.vec, {e.tag, " R6 vector"}, 32'(dec_hit_vec), 32'(e.vec));
      chk(dec_addr == e.addr, {e.tag, " address"}, dec_addr, e.addr);
    end
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    exp_t e;
    for (int i = 0; i < 6; i++) begin
      m_base[i] = 0; m_mask[i] = 0; m_xl[i] = 0; m_sp[i] = 0; m_xe[i] = 0;
    end
    m_mask[0] = 20'hFFF00;
    m_base[1] = 20'h80000; m_mask[1] = 20'hF0000; m_xl[1] = 20'h10000; m_xe[1] = 1;
    m_base[2] = 20'h40000; m_mask[2] = 20'hFFFFF; m_sp[2] = 1;

    rst_n = 0; req = 0; req_addr = 0; req_io = 0; wait_sel = 0;
    cfg_we = 0; cfg_img = 0; cfg_field = 0; cfg_data = 0;
    repeat (3) @(negedge clk);
    chk(dec_valid == 0 && dec_hit == 0 && dec_hit_vec == 0 && dec_addr == 0,
        "R8 outputs in reset", {dec_valid, dec_hit, dec_hit_vec, 24'(dec_addr[23:0])}, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R8 and R1: default image 0, low bits copied
    issue(32'h0001_2345, 0, 2'd0, "R8 R1 img0 default");
    issue(32'h0000_0FFF, 0, 2'd1, "R1 low bits");
    issue(32'h000F_FFFF, 0, 2'd1, "R2 masked-out bits ignored");
    // R5 translation on image 1
    issue(32'h8ABC_DEF0, 0, 2'd2, "R5 translate img1");
    // R3 space bit
    issue(32'h4000_0123, 0, 2'd0, "R3 mem vs io image miss");
    issue(32'h4000_0123, 1, 2'd0, "R3 io hit img2");
    issue(32'h0001_2345, 1, 2'd0, "R3 io vs mem image miss");
    // R4 zero mask
    issue(32'h3000_0000, 0, 2'd1, "R4 zero mask no hit");
    // R2 widen image 2
    issue(32'h400F_F000, 1, 2'd0, "R2 full mask miss");
    wcfg(3'd2, 3'd1, 20'hFFF00);
    issue(32'h400F_F000, 1, 2'd0, "R2 widened window hit");
    // R6 overlap: image 3 covers image 0
    wcfg(3'd3, 3'd1, 20'hF0000);
    issue(32'h0001_2345, 0, 2'd0, "R6 lowest index wins");
    issue(32'h0500_0000, 0, 2'd2, "R6 img3 alone");
    // R5 translation controls
    wcfg(3'd1, 3'd4, 20'h0);
    issue(32'h8ABC_DEF0, 0, 2'd0, "R5 translation disabled");
    wcfg(3'd3, 3'd3, 20'h70000);
    wcfg(3'd3, 3'd4, 20'h1);
    issue(32'h0500_0000, 0, 2'd1, "R5 translate img3");
    // R9 writes that must be ignored
    wcfg(3'd7, 3'd1, 20'h0);
    wcfg(3'd6, 3'd3, 20'h12345);
    wcfg(3'd3, 3'd6, 20'h0);
    wcfg(3'd3, 3'd7, 20'h0);
    issue(32'h0500_0000, 0, 2'd1, "R9 ignored writes");
    // R9 base field and R7 select value 3
    wcfg(3'd4, 3'd0, 20'hC0000);
    wcfg(3'd4, 3'd1, 20'hC0000);
    issue(32'hC123_4567, 0, 2'd3, "R9 R7 base write slow3");

    // R10: write sampled together with the strobe affects only the next request
    e = predict(32'h0001_2345, 0, 2'd2, "R10 write with strobe");
    @(negedge clk);
    req = 1; req_addr = 32'h0001_2345; req_io = 0; wait_sel = 2'd2;
    cfg_we = 1; cfg_img = 3'd0; cfg_field = 3'd1; cfg_data = 20'h0;
    @(negedge clk);
    req = 0; cfg_we = 0;
    model_write(3'd0, 3'd1, 20'h0);
    q.push_back(e);
    @(negedge clk);
    cfg_we = 1; cfg_img = 3'd3; cfg_field = 3'd2; cfg_data = 20'h1;
    @(negedge clk);
    cfg_we = 0;
    model_write(3'd3, 3'd2, 20'h1);
    repeat (2) @(negedge clk);
    held = dec_addr;
    repeat (4) @(negedge clk);
    chk(dec_valid == 1 && dec_addr == held && dec_img == 3'd0, "R10 result holds",
        dec_addr, held);
    issue(32'h0001_2345, 0, 2'd0, "R10 later request sees writes");
    issue(32'h0001_2345, 1, 2'd0, "R10 img3 now io");

    repeat (3) @(negedge clk);
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule